// File: doc/BRIEF.md
# Programmable FIFO Level Flag Unit

This block watches the occupancy count of a FIFO and drives three registered, active-low level flags: almost-full, almost-empty and half-full. The almost-full and almost-empty thresholds come from two offset registers, the empty offset `n` and the full offset `m`. Storage and pointer logic live elsewhere. The block only sees the count that the FIFO supplies. Everything runs on one clock.

While master reset is held, the level of `ld` decides two things. It picks the default value loaded into both offsets, and it picks how the offsets are programmed after reset.

In serial mode, the offsets are shifted in one bit per enabled clock from `ser_in`. In parallel mode, they are written as whole words from `din`. In either mode, they are read back on `dout` one word per access. A partial reset restarts the access sequence and clears `dout` and the flags, but keeps the offsets and the programming method.

Top module: `fifo_level_flags`

## Requirements
- R1: While `mrst_n` is low, `ld`=1 loads 1023 into both offsets and selects serial programming, and `ld`=0 loads 127 into both and selects parallel programming. In the first cycle after release with `occ`=0, the outputs read `afull_n`=1, `aempty_n`=0, `hfull_n`=1 and `dout`=0.
- R2: `afull_n` is registered and goes low one clock after `occ` is greater than DEPTH minus the full offset. Otherwise it is high.
- R3: `aempty_n` is registered and goes low one clock after `occ` is less than the empty offset. Otherwise it is high.
- R4: `hfull_n` is registered and goes low one clock after `occ` is greater than DEPTH/2. Otherwise it is high.
- R5: In parallel mode, a clock with `ld` and `wr_en` both high writes `din[OW-1:0]` into the offset named by an access select. The select starts at the empty offset and flips after each access.
- R6: A clock with `ld` and `rd_en` high and `wr_en` low puts the selected offset, zero-extended, on `dout` one clock later and flips the select. When `wr_en` is also high, the write wins and no read happens. `dout` holds its value otherwise.
- R7: In serial mode, each clock with `ser_en` high shifts `ser_in` into the offsets, least significant bit first: OW bits of the empty offset, then OW bits of the full offset. Bits beyond 2*OW are ignored.
- R8: Parallel writes have no effect in serial mode, and `ser_en` has no effect in parallel mode.
- R9: A clock with `prst_n` low leaves the offsets and the programming method unchanged. It returns the access select to the empty offset, restarts the serial bit count, clears `dout` to 0, and puts the flags in their R1 reset levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrst_n | input | 1 | Master reset, active low, synchronous |
| prst_n | input | 1 | Partial reset, active low, synchronous |
| ld | input | 1 | Mode/default select during master reset; offset access enable afterwards |
| wr_en | input | 1 | Offset write strobe (with `ld`) |
| rd_en | input | 1 | Offset read strobe (with `ld`) |
| ser_en | input | 1 | Serial shift enable |
| ser_in | input | 1 | Serial offset data |
| din | input | DATA_W | Parallel offset data |
| occ | input | DEPTH_LOG2+1 | FIFO occupancy count, 0 to DEPTH |
| afull_n | output | 1 | Almost-full flag, active low |
| aempty_n | output | 1 | Almost-empty flag, active low |
| hfull_n | output | 1 | Half-full flag, active low |
| dout | output | DATA_W | Offset readback data |

## Verification
The assertions assume that master reset is held low from the first clock edge. They check the offset-hold, select-toggle and readback-hold rules only outside master reset. They also assume that `occ` never exceeds DEPTH and that `ld` is steady across the reset edges that sample it.

The stimulus drives every input on the falling edge and starts each run with master reset already low. It keeps `occ` within 0 to DEPTH, and it changes `ld` only while the design is outside reset or before a reset sequence begins.

// File: rtl/fifo_level_flags.sv
module fifo_level_flags #(
  parameter int DEPTH_LOG2 = 13,
  parameter int DATA_W     = 18,
  parameter int DEF_LO     = 127,
  parameter int DEF_HI     = 1023
) (
  input  logic                  clk,
  input  logic                  mrst_n,
  input  logic                  prst_n,
  input  logic                  ld,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic                  ser_en,
  input  logic                  ser_in,
  input  logic [DATA_W-1:0]     din,
  input  logic [DEPTH_LOG2:0]   occ,
  output logic                  afull_n,
  output logic                  aempty_n,
  output logic                  hfull_n,
  output logic [DATA_W-1:0]     dout
);
  localparam int OW    = DEPTH_LOG2;
  localparam int CW    = DEPTH_LOG2 + 1;
  localparam int DEPTH = 1 << DEPTH_LOG2;
  localparam int SBITS = 2 * OW;
  localparam int SCW   = $clog2(SBITS + 1);

  logic [OW-1:0]  n_off, m_off;
  logic           ser_mode, sel_full;
  logic [SCW-1:0] scnt;

  wire soft_rst = !mrst_n || !prst_n;
  wire pwr      = ld && wr_en;
  wire prd      = ld && rd_en && !wr_en;
  wire shift    = ser_mode && ser_en && (scnt < SCW'(SBITS));
  wire pload    = !ser_mode && pwr;

  wire [CW-1:0] full_thr = CW'(DEPTH) - CW'(m_off);

  always_ff @(posedge clk) begin
    if (!mrst_n) begin
      ser_mode <= ld;
      n_off    <= ld ? OW'(DEF_HI) : OW'(DEF_LO);
      m_off    <= ld ? OW'(DEF_HI) : OW'(DEF_LO);
    end else if (prst_n) begin
      if (shift) begin
        for (int i = 0; i < OW; i++) begin
          if (scnt == SCW'(i))      n_off[i] <= ser_in;
          if (scnt == SCW'(i + OW)) m_off[i] <= ser_in;
        end
      end else if (pload) begin
        if (sel_full) m_off <= din[OW-1:0];
        else          n_off <= din[OW-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (soft_rst) begin
      sel_full <= 1'b0;
      scnt     <= '0;
      dout     <= '0;
    end else begin
      if (shift)         scnt     <= scnt + 1'b1;
      if (pload || prd)  sel_full <= ~sel_full;
      if (prd)           dout     <= DATA_W'(sel_full ? m_off : n_off);
    end
  end

  always_ff @(posedge clk) begin
    if (soft_rst) begin
      afull_n  <= 1'b1;
      aempty_n <= 1'b0;
      hfull_n  <= 1'b1;
    end else begin
      afull_n  <= !(occ > full_thr);
      aempty_n <= !(occ < CW'(n_off));
      hfull_n  <= !(occ > CW'(DEPTH / 2));
    end
  end

  assert_prst_keeps_offsets_R9: assert property (@(posedge clk) disable iff (!mrst_n)
    !prst_n |=> ($stable(n_off) && $stable(m_off) && $stable(ser_mode)));

  assert_parallel_ignores_serial_R8: assert property (@(posedge clk) disable iff (!mrst_n)
    (!ser_mode && !pwr) |=> ($stable(n_off) && $stable(m_off)));

  assert_serial_ignores_write_R8: assert property (@(posedge clk) disable iff (!mrst_n)
    (ser_mode && !ser_en) |=> ($stable(n_off) && $stable(m_off)));

  assert_serial_count_bound_R7: assert property (@(posedge clk) disable iff (!mrst_n)
    scnt <= SCW'(SBITS));

  assert_select_flips_on_read_R6: assert property (@(posedge clk) disable iff (!mrst_n)
    (prst_n && prd) |=> (sel_full != $past(sel_full)));

  assert_dout_holds_R6: assert property (@(posedge clk) disable iff (!mrst_n)
    (prst_n && !prd) |=> $stable(dout));

  assert_prst_clears_flags_R9: assert property (@(posedge clk) disable iff (!mrst_n)
    !prst_n |=> (afull_n && !aempty_n && hfull_n && dout == '0));
endmodule

// File: tb/fifo_level_flags_tb.sv
module fifo_level_flags_tb;
  localparam int LOG2 = 13;
  localparam int DW   = 18;

  logic clk = 1'b0;
  logic mrst_n = 1'b0, prst_n = 1'b1, ld = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic ser_en = 1'b0, ser_in = 1'b0;
  logic [DW-1:0] din = '0;
  logic [LOG2:0] occ = '0;
  logic afull_n, aempty_n, hfull_n;
  logic [DW-1:0] dout;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  fifo_level_flags u_dut (
    .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .ld(ld), .wr_en(wr_en),
    .rd_en(rd_en), .ser_en(ser_en), .ser_in(ser_in), .din(din), .occ(occ),
    .afull_n(afull_n), .aempty_n(aempty_n), .hfull_n(hfull_n), .dout(dout));

  // {occ[13:0], afull_n, aempty_n, hfull_n} with both offsets 127, DEPTH 8192
  localparam logic [16:0] VEC [9] = '{
    {14'd0,    3'b101}, {14'd126,  3'b101}, {14'd127,  3'b111},
    {14'd4096, 3'b111}, {14'd4097, 3'b110}, {14'd8065, 3'b110},
    {14'd8066, 3'b010}, {14'd8192, 3'b010}, {14'd50,   3'b101}};

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic flags(string req, int o, logic [2:0] exp);
    occ = o[LOG2:0];
    tick();
    chk(req, {29'd0, afull_n, aempty_n, hfull_n}, {29'd0, exp});
  endtask

  task automatic master_reset(logic mode);
    mrst_n = 1'b0; ld = mode; occ = '0;
    tick(); tick();
    mrst_n = 1'b1; ld = 1'b0;
  endtask

  task automatic pwrite(int v);
    ld = 1'b1; wr_en = 1'b1; din = v[DW-1:0];
    tick();
    ld = 1'b0; wr_en = 1'b0;
  endtask

  task automatic pread(string req, int exp);
    ld = 1'b1; rd_en = 1'b1;
    tick();
    ld = 1'b0; rd_en = 1'b0;
    chk(req, dout, exp);
  endtask

  task automatic shift_in(logic [25:0] bits, int count);
    for (int i = 0; i < count; i++) begin
      ser_en = 1'b1; ser_in = bits[i % 26];
      tick();
    end
    ser_en = 1'b0; ser_in = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    @(negedge clk);
    master_reset(1'b0);
    tick();
    chk("R1 reset flags", {29'd0, afull_n, aempty_n, hfull_n}, 32'b101);
    chk("R1 reset dout", dout, 0);

    for (int k = 0; k < 9; k++) begin
      string r;
      r = (k == 3 || k == 4) ? "R4" : (k >= 5 && k <= 7) ? "R2" : "R3";
      flags(r, int'(VEC[k][16:3]), VEC[k][2:0]);
    end

    pread("R1 default n 127", 127);
    pread("R1 default m 127", 127);

    pwrite(5);
    pwrite(100);
    flags("R3 n=5 below", 4, 3'b101);
    flags("R3 n=5 at", 5, 3'b111);
    flags("R2 m=100 at", 8092, 3'b110);
    flags("R2 m=100 above", 8093, 3'b010);
    pread("R5 n readback", 5);
    pread("R5 m readback", 100);

    shift_in(26'h3FFFFFF, 10);
    pread("R8 ser ignored parallel", 5);

    ld = 1'b1; wr_en = 1'b1; rd_en = 1'b1; din = 18'd9;
    tick();
    ld = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    chk("R6 write wins dout held", dout, 5);
    pread("R6 n after write-wins", 5);
    pread("R5 m overwritten", 9);

    occ = 14'd4097;
    prst_n = 1'b0;
    tick();
    prst_n = 1'b1;
    chk("R9 prst flags", {29'd0, afull_n, aempty_n, hfull_n}, 32'b101);
    chk("R9 prst dout", dout, 0);
    pread("R9 select back to n", 5);
    pread("R9 m kept", 9);

    master_reset(1'b1);
    pread("R1 default n 1023", 1023);
    pread("R1 default m 1023", 1023);
    pwrite(7);
    pread("R8 write ignored serial", 1023);
    pread("R8 write ignored serial m", 1023);

    shift_in({13'd300, 13'd200}, 26);
    shift_in(26'h3FFFFFF, 5);
    pread("R7 serial n", 200);
    pread("R7 serial m", 300);
    flags("R3 serial n below", 199, 3'b101);
    flags("R3 serial n at", 200, 3'b111);
    flags("R2 serial m at", 7892, 3'b110);
    flags("R2 serial m above", 7893, 3'b010);

    prst_n = 1'b0;
    tick();
    prst_n = 1'b1;
    shift_in({13'd40, 13'd30}, 26);
    pread("R9 serial restart n", 30);
    pread("R9 serial mode kept m", 40);

    finish_run();
  end
endmodule